// File: doc/BRIEF.md
# Flash Read-Mode Output Controller

This block is the read-path half of the command interface of a parallel NOR flash device, modelled synchronously to a system clock. Commands written on the bus choose what later reads return: the memory array, identification data (a maker code, a density code and one lock bit per block), or the status byte of an external write engine. The choice holds until another recognised command is written. The block drives a 16-bit data word together with a per-bit output-enable mask. A pad ring or a bus model uses that mask to tri-state each line. The array behind the block is a small computed placeholder. Programming and erasing happen outside it.

Bus strobes are sampled on the clock. A read drives the bus one clock after the strobes and the address are sampled. The bus has no valid/ready handshake. The flash protocol is strobe-timed, so a read owns the bus for as long as the strobes stay active, and the block does not apply back-pressure.

Top module: `flash_read_ctrl`

## Requirements
- R1: After reset the mode is array read and `dq_en` and `dq_out` are all zero. A reset applied in any mode returns reads to array data.
- R2: A command is taken from `cmd_data` on the first clock where `we_n` is high after being low, with the device selected. 0xFF selects array read, 0x90 selects identifier read and 0x70 selects status read. Any other code leaves the mode unchanged. A mode stays in force across any number of reads.
- R3: The device is selected only when all three bits of `ce_n` are low. With any bit high, no command is taken and `dq_en` is zero.
- R4: In identifier mode, block-relative word offset 0 returns 0x0089 with `dq_en` = 0xFFFF.
- R5: In identifier mode, word offset 1 returns the density code on the low byte: 0x16 for 32, 0x17 for 64 (the default), 0x18 for 128 and 0x1D for 256 Mbit. The high byte is 0x00.
- R6: In identifier mode, word offset 2 returns the lock bit of the block selected by `addr[ADDR_W-1:BLK_LSB]` in bit 0, with 1 meaning locked. All other bits are 0. Any other offset returns 0x0000. Lock bits come from `LOCK_MASK`, whose bit n belongs to block n (default 0xA5).
- R7: Identifier word offsets are taken from `addr[BLK_LSB-1:1]`. `addr[0]` has no effect.
- R8: 0x90 is ignored while `wsm_busy` is high and `wsm_suspended` is low. It is accepted when the engine is idle or suspended.
- R9: The status byte and the busy state are captured when a read begins, either when `oe_n` falls with the device selected or when selection arrives with `oe_n` low. They are then held until `oe_n` goes high or the device is deselected.
- R10: In a status read captured while the engine was busy and not suspended, only bit 7 carries the status MSB. `dq_en` = 0x0080 and all other data bits are 0.
- R11: In a status read captured while the engine was idle or suspended, `dq_out` = {0x00, status} with `dq_en` = 0xFFFF.
- R12: An array read returns word i = `addr[ARR_AW:1]` as {~i[7:0], i[7:0] ^ 0x3C} with `dq_en` = 0xFFFF. Outputs drive only when, on the previous clock, the device was selected, `oe_n` was low and `we_n` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 3 | Active-low chip enables, all low to select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable; command taken on its rise |
| addr | input | ADDR_W | Byte address, bit 0 is the lowest line |
| cmd_data | input | 8 | Command byte from the data bus |
| wsm_busy | input | 1 | Write engine running an operation |
| wsm_suspended | input | 1 | Running operation is suspended |
| wsm_status | input | 8 | Status byte from the write engine |
| dq_out | output | 16 | Read data |
| dq_en | output | 16 | Per-bit output enable for `dq_out` |

## Verification
The assertions assume that `we_n` and `oe_n` are never low in the same clock, and that `ce_n` stays all-low across the whole of a write pulse, so a command edge is always seen with the device selected. The stimulus tasks keep to this. A write raises `oe_n` before it lowers `we_n`, and it holds `ce_n` for one clock past the rising edge. A read holds its strobes and address steady for two clocks before sampling. The engine inputs change only while the device is deselected, or while `oe_n` is held low on purpose to show that the status latch holds.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_STATUS = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_STATUS = 8'h70;

  localparam logic [7:0] MAKER_CODE = 8'h89;

  // density in Mbit -> identification code
  function automatic logic [7:0] density_code(input int mbit);
    case (mbit)
      32:      density_code = 8'h16;
      64:      density_code = 8'h17;
      128:     density_code = 8'h18;
      256:     density_code = 8'h1D;
      default: density_code = 8'h00;
    endcase
  endfunction

  // placeholder array word for index i
  function automatic logic [15:0] array_word(input logic [7:0] i);
    array_word = {~i, i ^ 8'h3C};
  endfunction

endpackage

// File: rtl/frc_cmd_tracker.sv
module frc_cmd_tracker
  import flash_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       we_n,
  input  logic [7:0] cmd_data,
  input  logic       id_allowed,
  output rd_mode_e   mode
);

  logic we_q;
  logic commit;

  // rising edge of write enable while selected
  assign commit = sel && we_n && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      mode <= MODE_ARRAY;
    end else begin
      we_q <= we_n;
      if (commit) begin
        case (cmd_data)
          CMD_ARRAY:  mode <= MODE_ARRAY;
          CMD_STATUS: mode <= MODE_STATUS;
          CMD_IDENT:  if (id_allowed) mode <= MODE_IDENT;
          default:    mode <= mode;
        endcase
      end
    end
  end

endmodule

// File: rtl/frc_ident_mux.sv
module frc_ident_mux
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int BLK_LSB      = 7,
  parameter int DENSITY_MBIT = 64,
  parameter int NUM_BLOCKS   = 1 << (ADDR_W - BLK_LSB),
  parameter logic [NUM_BLOCKS-1:0] LOCK_MASK = '1
) (
  input  logic [ADDR_W-1:1] word_addr,
  output logic [15:0]       id_word
);

  localparam int OFF_W = BLK_LSB - 1;
  localparam int BLK_W = ADDR_W - BLK_LSB;

  logic [OFF_W-1:0] offset;
  logic [BLK_W-1:0] blk;
  logic             lock_bit;

  assign offset   = word_addr[BLK_LSB-1:1];
  assign blk      = word_addr[ADDR_W-1:BLK_LSB];
  assign lock_bit = LOCK_MASK[blk];

  always_comb begin
    id_word = 16'h0000;
    case (offset)
      OFF_W'(0): id_word = {8'h00, MAKER_CODE};
      OFF_W'(1): id_word = {8'h00, density_code(DENSITY_MBIT)};
      OFF_W'(2): id_word = {15'h0000, lock_bit};
      default:   id_word = 16'h0000;
    endcase
  end

endmodule

// File: rtl/frc_status_latch.sv
module frc_status_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       oe_n,
  input  logic [7:0] status_in,
  input  logic       busy_in,
  output logic [7:0] cur_status,
  output logic       cur_busy,
  output logic [7:0] lat_status,
  output logic       held
);

  logic lat_busy;
  logic capture;

  assign capture = sel && !oe_n && !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held       <= 1'b0;
      lat_status <= 8'h00;
      lat_busy   <= 1'b0;
    end else if (!sel || oe_n) begin
      held <= 1'b0;
    end else if (capture) begin
      held       <= 1'b1;
      lat_status <= status_in;
      lat_busy   <= busy_in;
    end
  end

  // value seen by the output stage in this cycle
  assign cur_status = capture ? status_in : lat_status;
  assign cur_busy   = capture ? busy_in   : lat_busy;

endmodule

// File: rtl/frc_out_stage.sv
module frc_out_stage
  import flash_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd,
  input  rd_mode_e    mode,
  input  logic [15:0] array_data,
  input  logic [15:0] id_data,
  input  logic [7:0]  status,
  input  logic        busy,
  output logic [15:0] dq_out,
  output logic [15:0] dq_en
);

  logic [15:0] nxt_dq;
  logic [15:0] nxt_en;

  always_comb begin
    nxt_dq = 16'h0000;
    nxt_en = 16'h0000;
    if (rd) begin
      case (mode)
        MODE_ARRAY: begin
          nxt_dq = array_data;
          nxt_en = 16'hFFFF;
        end
        MODE_IDENT: begin
          nxt_dq = id_data;
          nxt_en = 16'hFFFF;
        end
        MODE_STATUS: begin
          if (busy) begin
            nxt_dq = {8'h00, status[7], 7'h00};
            nxt_en = 16'h0080;
          end else begin
            nxt_dq = {8'h00, status};
            nxt_en = 16'hFFFF;
          end
        end
        default: begin
          nxt_dq = 16'h0000;
          nxt_en = 16'h0000;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= 16'h0000;
      dq_en  <= 16'h0000;
    end else begin
      dq_out <= nxt_dq;
      dq_en  <= nxt_en;
    end
  end

endmodule

// File: rtl/flash_read_ctrl.sv
module flash_read_ctrl
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int BLK_LSB      = 7,
  parameter int ARR_AW       = 4,
  parameter int DENSITY_MBIT = 64,
  parameter logic [(1 << (ADDR_W - BLK_LSB))-1:0] LOCK_MASK = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmd_data,
  input  logic              wsm_busy,
  input  logic              wsm_suspended,
  input  logic [7:0]        wsm_status,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_en
);

  localparam int NUM_BLOCKS = 1 << (ADDR_W - BLK_LSB);
  localparam int ARR_DEPTH  = 1 << ARR_AW;

  logic        sel;
  logic        rd;
  logic        engine_busy;
  rd_mode_e    mode;
  logic [15:0] id_word;
  logic [15:0] arr_word;
  logic [7:0]  st_cur;
  logic        st_cur_busy;
  logic [7:0]  st_lat;
  logic        st_held;
  logic [15:0] rom [ARR_DEPTH];

  assign sel         = (ce_n == 3'b000);
  assign rd          = sel && !oe_n && we_n;
  assign engine_busy = wsm_busy && !wsm_suspended;

  // placeholder array contents, one computed word per index
  for (genvar g = 0; g < ARR_DEPTH; g++) begin : g_rom
    assign rom[g] = array_word(8'(g));
  end
  assign arr_word = rom[addr[ARR_AW:1]];

  frc_cmd_tracker u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .we_n       (we_n),
    .cmd_data   (cmd_data),
    .id_allowed (!engine_busy),
    .mode       (mode)
  );

  frc_ident_mux #(
    .ADDR_W       (ADDR_W),
    .BLK_LSB      (BLK_LSB),
    .DENSITY_MBIT (DENSITY_MBIT),
    .NUM_BLOCKS   (NUM_BLOCKS),
    .LOCK_MASK    (LOCK_MASK)
  ) u_ident (
    .word_addr (addr[ADDR_W-1:1]),
    .id_word   (id_word)
  );

  frc_status_latch u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .oe_n       (oe_n),
    .status_in  (wsm_status),
    .busy_in    (engine_busy),
    .cur_status (st_cur),
    .cur_busy   (st_cur_busy),
    .lat_status (st_lat),
    .held       (st_held)
  );

  frc_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd         (rd),
    .mode       (mode),
    .array_data (arr_word),
    .id_data    (id_word),
    .status     (st_cur),
    .busy       (st_cur_busy),
    .dq_out     (dq_out),
    .dq_en      (dq_en)
  );

endmodule

// File: rtl/frc_checker.sv
module frc_checker
  import flash_rd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  ce_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        wsm_busy,
  input logic        wsm_suspended,
  input rd_mode_e    mode,
  input logic        held,
  input logic [7:0]  lat_status,
  input logic [15:0] dq_out,
  input logic [15:0] dq_en
);

  assert_drive_needs_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_en != 16'h0000) |-> $past(ce_n == 3'b000 && !oe_n && we_n));

  assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n != 3'b000) |-> (dq_en == 16'h0000));

  assert_enable_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_en == 16'h0000) || (dq_en == 16'h0080) || (dq_en == 16'hFFFF));

  assert_busy_only_msb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_en == 16'h0080) |-> (dq_out[15:8] == 8'h00 && dq_out[6:0] == 7'h00));

  assert_mode_on_write_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> ($past(ce_n == 3'b000 && we_n) && $past(!we_n, 2)));

  assert_ident_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDENT && $past(mode) != MODE_IDENT) |-> $past(!wsm_busy || wsm_suspended));

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> $stable(lat_status));

endmodule

bind flash_read_ctrl frc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ce_n          (ce_n),
  .oe_n          (oe_n),
  .we_n          (we_n),
  .wsm_busy      (wsm_busy),
  .wsm_suspended (wsm_suspended),
  .mode          (mode),
  .held          (st_held),
  .lat_status    (st_lat),
  .dq_out        (dq_out),
  .dq_en         (dq_en)
);

// File: tb/flash_read_ctrl_tb.sv
module flash_read_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  // {is_read, addr[9:0], cmd[7:0], expected dq[15:0], requirement number[3:0]}
  localparam int NVEC = 15;
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b1, 10'h000, 8'h00, 16'hFF3C, 4'd12}, // R12 word 0
    {1'b1, 10'h006, 8'h00, 16'hFC3F, 4'd12}, // R12 word 3
    {1'b0, 10'h000, 8'h90, 16'h0000, 4'd2 }, // R2 identifier command
    {1'b1, 10'h000, 8'h00, 16'h0089, 4'd4 }, // R4 maker code
    {1'b1, 10'h001, 8'h00, 16'h0089, 4'd7 }, // R7 A0 set, same word
    {1'b1, 10'h002, 8'h00, 16'h0017, 4'd5 }, // R5 64 Mbit code
    {1'b1, 10'h004, 8'h00, 16'h0001, 4'd6 }, // R6 block 0 locked
    {1'b1, 10'h084, 8'h00, 16'h0000, 4'd6 }, // R6 block 1 unlocked
    {1'b1, 10'h105, 8'h00, 16'h0001, 4'd7 }, // R7 block 2 with A0 set
    {1'b1, 10'h006, 8'h00, 16'h0000, 4'd6 }, // R6 offset 3 reads zero
    {1'b0, 10'h000, 8'h42, 16'h0000, 4'd2 }, // R2 unknown code
    {1'b1, 10'h000, 8'h00, 16'h0089, 4'd2 }, // R2 mode kept
    {1'b0, 10'h000, 8'hFF, 16'h0000, 4'd2 }, // R2 back to array
    {1'b1, 10'h006, 8'h00, 16'hFC3F, 4'd2 }, // R2 array again
    {1'b1, 10'h01E, 8'h00, 16'hF033, 4'd12}  // R12 last word
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ce_n = 3'b111;
  logic        oe_n = 1'b1;
  logic        we_n = 1'b1;
  logic [9:0]  addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        wsm_busy = 1'b0;
  logic        wsm_suspended = 1'b0;
  logic [7:0]  wsm_status = '0;
  logic [15:0] dq_out;
  logic [15:0] dq_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_read_ctrl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ce_n          (ce_n),
    .oe_n          (oe_n),
    .we_n          (we_n),
    .addr          (addr),
    .cmd_data      (cmd_data),
    .wsm_busy      (wsm_busy),
    .wsm_suspended (wsm_suspended),
    .wsm_status    (wsm_status),
    .dq_out        (dq_out),
    .dq_en         (dq_en)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      failures++;
      $display("FAIL watchdog all-reqs actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [15:0] act_dq, input logic [15:0] exp_dq,
                       input logic [15:0] act_en, input logic [15:0] exp_en);
    checks++;
    if (act_dq !== exp_dq || act_en !== exp_en) begin
      failures++;
      $display("FAIL %s actual dq=%h en=%h expected dq=%h en=%h", req, act_dq, act_en, exp_dq, exp_en);
    end
  endtask

  task automatic write_cmd(input logic [7:0] c, input logic [2:0] ce);
    @(negedge clk);
    oe_n = 1'b1; ce_n = ce; cmd_data = c; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 3'b111;
    @(negedge clk);
  endtask

  task automatic read_word(input logic [9:0] a, input logic [2:0] ce,
                           output logic [15:0] d, output logic [15:0] e);
    @(negedge clk);
    ce_n = ce; addr = a; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    d = dq_out; e = dq_en;
    oe_n = 1'b1; ce_n = 3'b111;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    logic [15:0] e;
    string tag;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", dq_out, 16'h0000, dq_en, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", dq_out, 16'h0000, dq_en, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      if (VEC[i][38]) begin
        read_word(VEC[i][37:28], 3'b000, d, e);
        check(tag, d, VEC[i][19:4], e, 16'hFFFF);
      end else begin
        write_cmd(VEC[i][27:20], 3'b000);
      end
    end

    // R3: partial select drives nothing, and ignores commands
    read_word(10'h000, 3'b110, d, e);
    check("R3", d, 16'h0000, e, 16'h0000);
    write_cmd(8'h90, 3'b011);
    read_word(10'h000, 3'b000, d, e);
    check("R3", d, 16'hFF3C, e, 16'hFFFF);

    // R12: no drive with we_n low
    @(negedge clk);
    ce_n = 3'b000; oe_n = 1'b0; we_n = 1'b0; cmd_data = 8'h00;
    repeat (2) @(negedge clk);
    check("R12", dq_out, 16'h0000, dq_en, 16'h0000);
    oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    ce_n = 3'b111;
    @(negedge clk);

    // R8: identifier refused while busy, accepted when suspended
    wsm_busy = 1'b1; wsm_suspended = 1'b0;
    write_cmd(8'h90, 3'b000);
    read_word(10'h000, 3'b000, d, e);
    check("R8", d, 16'hFF3C, e, 16'hFFFF);
    wsm_suspended = 1'b1;
    write_cmd(8'h90, 3'b000);
    read_word(10'h000, 3'b000, d, e);
    check("R8", d, 16'h0089, e, 16'hFFFF);

    // R10: busy status drives bit 7 only
    write_cmd(8'h70, 3'b000);
    wsm_suspended = 1'b0; wsm_status = 8'h80;
    read_word(10'h000, 3'b000, d, e);
    check("R10", d, 16'h0080, e, 16'h0080);
    wsm_status = 8'h7F;
    read_word(10'h000, 3'b000, d, e);
    check("R10", d, 16'h0000, e, 16'h0080);

    // R11: suspended and idle status drive full byte
    wsm_suspended = 1'b1; wsm_status = 8'hC0;
    read_word(10'h000, 3'b000, d, e);
    check("R11", d, 16'h00C0, e, 16'hFFFF);
    wsm_busy = 1'b0; wsm_suspended = 1'b0; wsm_status = 8'hA2;
    read_word(10'h000, 3'b000, d, e);
    check("R11", d, 16'h00A2, e, 16'hFFFF);

    // R9: latch holds while oe_n stays low, refreshes on oe_n and select edges
    @(negedge clk);
    ce_n = 3'b000; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", dq_out, 16'h00A2, dq_en, 16'hFFFF);
    wsm_status = 8'h81;
    repeat (2) @(negedge clk);
    check("R9", dq_out, 16'h00A2, dq_en, 16'hFFFF);
    oe_n = 1'b1;
    @(negedge clk);
    oe_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", dq_out, 16'h0081, dq_en, 16'hFFFF);
    wsm_status = 8'hC4;
    ce_n = 3'b111;
    @(negedge clk);
    check("R3", dq_out, 16'h0000, dq_en, 16'h0000);
    ce_n = 3'b000;
    repeat (2) @(negedge clk);
    check("R9", dq_out, 16'h00C4, dq_en, 16'hFFFF);
    oe_n = 1'b1; ce_n = 3'b111;
    @(negedge clk);

    // R1: reset from identifier mode returns to array reads
    write_cmd(8'h90, 3'b000);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_word(10'h000, 3'b000, d, e);
    check("R1", d, 16'hFF3C, e, 16'hFFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule